// File: doc/BRIEF.md
# Programmable Watchdog Countdown Timer

This block is a software-supervised watchdog for a real-time-clock style device. Firmware picks one of four count rates and loads an 8-bit start value. The block then counts down once per rate tick. When the count reaches one, a sticky flag is raised and drives an active-high interrupt line. The counter then rests at zero and does not reload. To keep the interrupt from firing, firmware must load a value again before the period runs out. That write also clears the flag and restarts the count. Writing zero clears the flag and parks the timer.

The block takes a single-cycle 4.096 kHz enable pulse from the clock domain of the system. An internal prescaler derives the slower rates from that pulse. The prescaler restarts on every load, so the first period after a load is exact to within one 4.096 kHz tick. A small register bus drives the block through plain read and write strobes with a 2-bit address. It has a control register, a value register and a status register. Reading the status register clears the flag.

Top module: `wdog_cntdn`

## Requirements
- R1: After reset, the interrupt line is low, the control register reads 0 (disabled, rate 00) and the value register reads 0.
- R2: At rate 00 (control bits 2:1 = 00, enable = bit 0 of address 0), a loaded value n raises the interrupt on the n-th 4.096 kHz tick after the load, and not on any earlier tick.
- R3: Rates 01, 10 and 11 advance the count once every MID_DIV, SEC_DIV and SEC_DIV*MIN_MUL input ticks. The default dividers are 64, 4096 and 245760. A load restarts this division.
- R4: When the count reaches one, the flag (status bit 0) is set and the interrupt goes high. The count then stays at 0 without reloading, however many ticks follow.
- R5: A write of a nonzero n to address 1 clears the flag and the interrupt and restarts the countdown from n.
- R6: A write of 0 to address 1 clears the flag and the interrupt and stops the countdown.
- R7: A write to the status register (address 2), with either 0 or 1 in bit 0, does not change the flag.
- R8: A read of address 2 returns the flag in bit 0 and clears the flag after that cycle.
- R9: A status read in the same cycle as a flag-setting tick leaves the flag set.
- R10: While enable is 0, the count holds its value, no flag is raised and the prescaler pauses. Counting resumes on re-enable.
- R11: A read of address 1 returns the current count, a read of address 0 returns the control bits, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_4k | input | 1 | Single-cycle 4.096 kHz enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on status only) |
| addr | input | 2 | Register address: 0 control, 1 value, 2 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Active-high watchdog interrupt |

## Verification
On every cycle, the assertions check that a value load drops the interrupt and that the interrupt only rises out of a count of one. They also check that the count never climbs except by a load, that it freezes while disabled, that a status write leaves a raised flag alone, and that a status read clears the flag. Only the bench scenarios can show the exact tick on which the flag appears for each rate, the prescaler restart after a load, the read-back values, and the same-cycle race between a status read and a flag-setting tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int VAL_W = 8;

    typedef enum logic [1:0] {
        RATE_FAST = 2'b00,
        RATE_MID  = 2'b01,
        RATE_SEC  = 2'b10,
        RATE_MIN  = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_VALUE  = 2'd1,
        A_STATUS = 2'd2,
        A_NONE   = 2'd3
    } reg_addr_e;

    // Control layout: bit 0 enable, bits 2:1 rate
    typedef struct packed {
        rate_e rate;
        logic  en;
    } ctrl_t;

    // Bus-side commands handed to the counter
    typedef struct packed {
        logic             load;
        logic [VAL_W-1:0] value;
        logic             stat_rd;
    } cmd_t;

    // Last prescaler state (divide ratio minus one) for a rate
    function automatic int unsigned rate_last(rate_e r, int unsigned mid,
                                              int unsigned sec, int unsigned lng);
        case (r)
            RATE_FAST: return 0;
            RATE_MID:  return mid - 1;
            RATE_SEC:  return sec - 1;
            default:   return lng - 1;
        endcase
    endfunction

endpackage

// File: rtl/wdog_presc.sv
module wdog_presc
    import wdog_pkg::*;
#(
    parameter int unsigned MID_DIV  = 64,
    parameter int unsigned SEC_DIV  = 4096,
    parameter int unsigned LONG_DIV = 245760,
    localparam int PW = (LONG_DIV > 2) ? $clog2(LONG_DIV) : 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  rate_e rate,
    input  logic  tick_in,
    input  logic  restart,
    output logic  src_tick
);
    logic [PW-1:0] pcnt_q;
    logic [31:0]   last;
    logic          at_last;

    always_comb begin
        last    = 32'(rate_last(rate, MID_DIV, SEC_DIV, LONG_DIV));
        at_last = 32'(pcnt_q) >= last;
        src_tick = en && tick_in && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt_q <= '0;
        end else if (en && tick_in) begin
            if (at_last) pcnt_q <= '0;
            else         pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             src_tick,
    input  cmd_t             cmd,
    output logic [VAL_W-1:0] cnt,
    output logic             flag
);
    logic [VAL_W-1:0] cnt_q;
    logic             flag_q;
    logic             step;
    logic             hit;

    always_comb begin
        step = en && src_tick && (cnt_q != '0);
        hit  = step && (cnt_q == VAL_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (cmd.load) begin
            cnt_q  <= cmd.value;
            flag_q <= 1'b0;
        end else begin
            if (step) cnt_q <= cnt_q - 1'b1;
            // a set event outranks a clearing status read
            if (hit)              flag_q <= 1'b1;
            else if (cmd.stat_rd) flag_q <= 1'b0;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [VAL_W-1:0] cnt,
    input  logic             flag,
    output ctrl_t            ctrl,
    output cmd_t             cmd,
    output logic [7:0]       rdata
);
    ctrl_t     ctrl_q;
    reg_addr_e a;

    assign a = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst)                      ctrl_q <= '0;
        else if (wr_en && a == A_CTRL) ctrl_q <= ctrl_t'(wdata[2:0]);
    end

    always_comb begin
        cmd.load    = wr_en && (a == A_VALUE);
        cmd.value   = wdata[VAL_W-1:0];
        cmd.stat_rd = rd_en && (a == A_STATUS);
        case (a)
            A_CTRL:   rdata = {5'b0, ctrl_q};
            A_VALUE:  rdata = 8'(cnt);
            A_STATUS: rdata = {7'b0, flag};
            default:  rdata = 8'h00;
        endcase
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/wdog_cntdn.sv
module wdog_cntdn
    import wdog_pkg::*;
#(
    parameter int unsigned MID_DIV = 64,
    parameter int unsigned SEC_DIV = 4096,
    parameter int unsigned MIN_MUL = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_4k,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    localparam int unsigned LONG_DIV = SEC_DIV * MIN_MUL;

    ctrl_t            ctrl_q;
    cmd_t             cmd;
    logic [VAL_W-1:0] count_q;
    logic             flag_q;
    logic             src_tick;

    wdog_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .cnt(count_q), .flag(flag_q), .ctrl(ctrl_q),
        .cmd(cmd), .rdata(rdata)
    );

    wdog_presc #(.MID_DIV(MID_DIV), .SEC_DIV(SEC_DIV), .LONG_DIV(LONG_DIV)) u_presc (
        .clk(clk), .rst(rst), .en(ctrl_q.en), .rate(ctrl_q.rate),
        .tick_in(tick_4k), .restart(cmd.load), .src_tick(src_tick)
    );

    wdog_counter u_cnt (
        .clk(clk), .rst(rst), .en(ctrl_q.en), .src_tick(src_tick),
        .cmd(cmd), .cnt(count_q), .flag(flag_q)
    );

    assign irq = flag_q;
endmodule

// File: rtl/wdog_cntdn_chk.sv
module wdog_cntdn_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       irq,
    input logic [7:0] cnt,
    input logic       en
);
    logic val_wr, stat_wr, stat_rd;
    assign val_wr  = wr_en && addr == 2'd1;
    assign stat_wr = wr_en && addr == 2'd2;
    assign stat_rd = rd_en && addr == 2'd2;

    // R5
    load_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        val_wr |=> !irq);

    // R4
    irq_from_one_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(cnt) == 8'd1);

    // R2
    no_climb_chk: assert property (@(posedge clk) disable iff (rst)
        !val_wr |=> cnt <= $past(cnt));

    // R10
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !val_wr) |=> $stable(cnt));

    // R7
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && stat_wr) |=> irq);

    // R8
    stat_rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && cnt != 8'd1) |=> !irq);
endmodule

bind wdog_cntdn wdog_cntdn_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .irq(irq), .cnt(count_q), .en(ctrl_q.en)
);

// File: tb/wdog_cntdn_test.sv
module wdog_cntdn_test;
    localparam int CLK_PERIOD = 10;
    localparam int MID = 4;
    localparam int SEC = 16;
    localparam int MUL = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_4k = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    wdog_cntdn #(.MID_DIV(MID), .SEC_DIV(SEC), .MIN_MUL(MUL)) uut (
        .clk(clk), .rst(rst), .tick_4k(tick_4k), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // read without side effect unless a == 2
    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(int k);
        if (k > 0) begin
            @(negedge clk); tick_4k = 1'b1;
            repeat (k) @(negedge clk);
            tick_4k = 1'b0;
        end
    endtask

    task automatic count_is(string req, int exp);
        logic [7:0] d;
        rd(2'd1, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 irq", irq, 0);
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 value", d, 0);
    endtask

    task automatic t_fast;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'd5);
        ticks(4);
        chk("R2 early", irq, 0);
        count_is("R2 count", 1);
        ticks(1);
        chk("R2 on time", irq, 1);
        ticks(3);
        chk("R4 irq stays", irq, 1);
        count_is("R4 no reload", 0);
    endtask

    task automatic t_status_read;
        logic [7:0] d;
        rd(2'd2, d);
        chk("R8 flag bit", d, 1);
        chk("R8 cleared", irq, 0);
        rd(2'd2, d);
        chk("R8 reads 0", d, 0);
    endtask

    task automatic t_status_write;
        wr(2'd1, 8'd1);
        ticks(1);
        chk("R4 n=1", irq, 1);
        wr(2'd2, 8'h00);
        chk("R7 write 0", irq, 1);
        wr(2'd2, 8'h01);
        chk("R7 write 1", irq, 1);
        wr(2'd1, 8'd3);
        chk("R5 irq cleared", irq, 0);
        count_is("R5 restart", 3);
        ticks(3);
        chk("R5 period", irq, 1);
    endtask

    task automatic t_zero;
        wr(2'd1, 8'd0);
        chk("R6 irq cleared", irq, 0);
        wr(2'd1, 8'd3);
        ticks(1);
        count_is("R6 running", 2);
        wr(2'd1, 8'd0);
        ticks(5);
        chk("R6 stopped irq", irq, 0);
        count_is("R6 stopped count", 0);
    endtask

    task automatic t_rates;
        wr(2'd0, 8'h03);
        wr(2'd1, 8'd2);
        ticks(2 * MID - 1);
        chk("R3 mid early", irq, 0);
        ticks(1);
        chk("R3 mid", irq, 1);
        wr(2'd1, 8'd1);
        ticks(2);
        wr(2'd1, 8'd1);
        ticks(MID - 1);
        chk("R3 restart early", irq, 0);
        ticks(1);
        chk("R3 restart", irq, 1);
        wr(2'd0, 8'h05);
        wr(2'd1, 8'd1);
        ticks(SEC - 1);
        chk("R3 sec early", irq, 0);
        ticks(1);
        chk("R3 sec", irq, 1);
        wr(2'd0, 8'h07);
        wr(2'd1, 8'd1);
        ticks(SEC * MUL - 1);
        chk("R3 min early", irq, 0);
        ticks(1);
        chk("R3 min", irq, 1);
    endtask

    task automatic t_race;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'd1);
        @(negedge clk); tick_4k = 1'b1; rd_en = 1'b1; addr = 2'd2;
        @(negedge clk); tick_4k = 1'b0; rd_en = 1'b0;
        chk("R9 flag kept", irq, 1);
    endtask

    task automatic t_disable;
        logic [7:0] d;
        wr(2'd1, 8'd4);
        ticks(1);
        wr(2'd0, 8'h00);
        ticks(10);
        count_is("R10 held", 3);
        chk("R10 no irq", irq, 0);
        wr(2'd0, 8'h01);
        ticks(2);
        chk("R10 resume early", irq, 0);
        ticks(1);
        chk("R10 resume", irq, 1);
        rd(2'd0, d); chk("R11 ctrl readback", d, 1);
        rd(2'd3, d); chk("R11 addr3", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fast();
        t_status_read();
        t_status_write();
        t_zero();
        t_rates();
        t_race();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule